// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front-End

This block is the bus-facing half of a small two-wire serial memory. It runs on a fast system clock and oversamples the bus clock and data lines. Each line passes through a synchronizer and a stable-count glitch filter. The block then recognises start and stop conditions and shifts 8-bit words in and out, most significant bit first. The data line is open-drain, so the block only asserts a pull-low enable and otherwise leaves the line high through the external pull-up. The storage itself sits outside the block. It is reached through a write request channel and a read request channel, and both use a valid/ready handshake.

A transfer opens with a device byte. Its upper seven bits must match `DEV_ADDR`, and its low bit selects read (1) or write (0). In a write, the next byte sets the word address and every byte after that is written to storage. In a read, bytes are returned from the current address. After each byte the address pointer steps up by one and wraps at the top of the address range.

A stop that ends a write that stored at least one byte starts a busy interval of `WRITE_CYC` clocks. This interval stands in for the internal write cycle. While it lasts, the device byte is not acknowledged, so the master can poll until the write has finished. The `standby` output reports the power state. It is high after reset and after a stop, and it stays low while a transfer is open or the busy interval is running.

Write channel back-pressure: `wr_valid`, `wr_addr` and `wr_data` are held steady until the cycle in which `wr_ready` is high. The storage may hold off the request for any number of clocks shorter than one byte time on the bus. Read channel: `rd_valid` and `rd_addr` are held until `rd_ready` is high, and `rd_data` is taken in that same cycle. The data must arrive before the clock edge at which the byte starts to shift out.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset `standby`=1, `busy`=0, `sda_low`=0, `wr_valid`=0 and `rd_valid`=0.
- R2: A start is a high-to-low change on SDA while SCL is high. A start drops `standby` to 0. Bits clocked on the bus before any start get no acknowledge and cause no write.
- R3: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` system clocks is ignored, so a short low pulse on SDA while SCL is high is not taken as a start.
- R4: After 8 bits the block acknowledges by holding `sda_low`=1 through the ninth SCL clock, but only when bits 7:1 of the device byte equal `DEV_ADDR`. On a mismatch it keeps SDA released until the next start. `sda_low` changes only while the filtered SCL is low.
- R5: In a write (device byte bit 0 = 0), the second byte is the word address. Each later byte is acknowledged and produces one write request with `wr_addr` = word address + n and that byte as `wr_data`, held until `wr_ready`.
- R6: A stop after at least one stored byte raises `busy` for `WRITE_CYC` clocks. While `busy` is high, the device byte is not acknowledged.
- R7: After a stop, `standby` returns to 1 as soon as `busy` is 0. `standby` is never 1 while `busy` is 1.
- R8: In a read (device byte bit 0 = 1), the block requests the byte at the current address and shifts it out MSB first, pulling SDA low for each 0 bit. The address advances by one per byte returned.
- R9: On the ninth clock of a read byte the block releases SDA. A 0 from the master continues with the next byte. A 1 ends the read, and SDA stays released until a stop or start.
- R10: A start in the middle of a byte abandons that byte and restarts reception with a new device byte.
- R11: A read with no word address returns data from the address after the last byte written or read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as sensed at the pad |
| sda_in | input | 1 | Bus data line as sensed at the pad |
| sda_low | output | 1 | Pull-low enable for the open-drain data pad |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Storage accepts the write request |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 8 | Write byte |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Storage returns `rd_data` this cycle |
| rd_addr | output | AW | Read byte address |
| rd_data | input | 8 | Read byte from storage |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Low-power standby state |

## Verification
A wrong controller state shows up at the ports within a single bus bit. It appears as a missing or extra pull-low on the ninth clock, or as a data bit that comes out wrong in the next read byte. An error in the address pointer or the byte kind shows up on `wr_addr`, or in the bytes read back after the next write and its busy interval, which is one transfer later. An error in the filter or the condition detector changes `standby` within a few clocks of the bus edge. It also causes the acknowledge of the following device byte to go missing.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_WAIT
  } fe_state_t;

  typedef enum logic [1:0] {
    K_DEV, K_WORD, K_DATA
  } byte_kind_t;
endpackage

// File: rtl/twi_glitch_filt.sv
module twi_glitch_filt #(
  parameter int STABLE = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE + 1);
  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11;
      cnt  <= '0;
      dout <= 1'b1;
    end else begin
      sync <= {sync[0], din};
      if (sync[1] == dout) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        dout <= sync[1];
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = !scl_q && scl_f;
  assign scl_fall  = scl_q && !scl_f;
  assign start_det = scl_q && scl_f && sda_q && !sda_f;
  assign stop_det  = scl_q && scl_f && !sda_q && sda_f;
endmodule

// File: rtl/twi_busy_timer.sv
module twi_busy_timer #(
  parameter int CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic busy
);
  localparam int BW = $clog2(CYC + 1);
  logic [BW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (go)        cnt <= BW'(CYC);
    else if (cnt != '0) cnt <= cnt - BW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter int         AW        = 8,
  parameter int         FILT_CYC  = 5,
  parameter int         WRITE_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_low,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          standby
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, filt;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < NLINE; g++) begin : g_filt
    twi_glitch_filt #(.STABLE(FILT_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .dout(filt[g])
    );
  end

  assign scl_f = filt[1];
  assign sda_f = filt[0];

  twi_bus_events u_ev (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  logic wr_go;
  twi_busy_timer #(.CYC(WRITE_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .busy(busy)
  );

  fe_state_t     st;
  byte_kind_t    kind;
  logic [7:0]    shreg, rd_byte;
  logic [3:0]    bitcnt;
  logic [AW-1:0] addr;
  logic          rnw, drive, active, wrote, nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  kind <= K_DEV;  shreg <= '0;  rd_byte <= '0;
      bitcnt <= '0;   addr <= '0;     rnw <= 1'b0;  drive <= 1'b0;
      active <= 1'b0; wrote <= 1'b0;  nack <= 1'b0; wr_go <= 1'b0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      rd_valid <= 1'b0; rd_addr <= '0;
    end else begin
      wr_go <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
        rd_byte  <= rd_data;
      end
      if (start_det) begin
        st <= ST_RX;  kind <= K_DEV;  bitcnt <= '0;
        drive <= 1'b0; rnw <= 1'b0;   active <= 1'b1;
      end else if (stop_det) begin
        st <= ST_IDLE; drive <= 1'b0; active <= 1'b0;
        if (wrote) begin
          wr_go <= 1'b1;
          wrote <= 1'b0;
        end
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              unique case (kind)
                K_DEV: begin
                  if (shreg[7:1] == DEV_ADDR && !busy) begin
                    drive <= 1'b1;
                    st    <= ST_ACK;
                    rnw   <= shreg[0];
                    if (shreg[0]) begin
                      rd_valid <= 1'b1;
                      rd_addr  <= addr;
                    end
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                K_WORD: begin
                  addr  <= AW'(shreg);
                  drive <= 1'b1;
                  st    <= ST_ACK;
                end
                default: begin
                  wr_valid <= 1'b1;
                  wr_addr  <= addr;
                  wr_data  <= shreg;
                  addr     <= addr + AW'(1);
                  wrote    <= 1'b1;
                  drive    <= 1'b1;
                  st       <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rnw) begin
                shreg <= rd_byte;
                drive <= ~rd_byte[7];
                addr  <= addr + AW'(1);
                st    <= ST_TX;
              end else begin
                drive <= 1'b0;
                st    <= ST_RX;
                kind  <= (kind == K_DEV) ? K_WORD : K_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                drive    <= 1'b0;
                st       <= ST_RACK;
                rd_valid <= 1'b1;
                rd_addr  <= addr;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                drive  <= ~shreg[6];
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_f;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_WAIT;
              end else begin
                shreg  <= rd_byte;
                drive  <= ~rd_byte[7];
                addr   <= addr + AW'(1);
                bitcnt <= '0;
                st     <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_low = drive;
  assign standby = !active && !busy;
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk
  import twi_mem_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input fe_state_t     st,
  input logic          sda_low,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          standby
);
  a_r4_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low) |-> !scl_f);
  a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_low);
  a_r7_busy_no_standby: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby);
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
  a_r6_busy_lasts: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .st(st), .sda_low(sda_low),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .busy(busy), .standby(standby)
);

// File: tb/sim_twi_mem_slave.sv
`timescale 1ns/1ps
module sim_twi_mem_slave;
  localparam int AW = 8;
  localparam int WCYC = 3000;
  localparam logic [7:0] DEV_W = 8'hA0, DEV_R = 8'hA1, DEV_BAD = 8'hA2;
  localparam logic [15:0] VEC [0:3] = '{16'h10_3C, 16'h11_A5, 16'h12_00, 16'h13_FF};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, m_low = 1'b0;
  logic sda_low, wr_valid, rd_valid, busy, standby;
  logic wr_ready, rd_ready = 1'b0;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data = '0;
  wire sda_bus = ~(m_low | sda_low);

  int n_chk = 0, n_fail = 0, n_wr = 0, cyc = 0;
  logic [7:0] last_wa, last_wd;
  logic [7:0] mem [256];
  logic       mem_w [256];
  logic [7:0] exp_m [256];

  always #5 clk = ~clk;

  twi_mem_slave #(.DEV_ADDR(7'h50), .AW(AW), .FILT_CYC(5), .WRITE_CYC(WCYC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_low(sda_low),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .standby(standby)
  );

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'hC3;
  endfunction

  // storage model: write accepted on alternate cycle pairs, read answered next cycle
  assign wr_ready = cyc[1];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_ready <= rd_valid && !rd_ready;
    rd_data  <= (rst_n && mem_w[rd_addr]) ? mem[rd_addr] : init_val(int'(rd_addr));
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_w[i] <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      mem[wr_addr]   <= wr_data;
      mem_w[wr_addr] <= 1'b1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
      n_wr    <= n_wr + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input bit drv_low, output bit seen);
    wait_cyc(20); m_low = drv_low;
    wait_cyc(20); scl = 1'b1;
    wait_cyc(20); seen = sda_bus;
    wait_cyc(20); scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_cyc(20); m_low = 1'b0;
    wait_cyc(20); scl = 1'b1;
    wait_cyc(20); m_low = 1'b1;
    wait_cyc(20); scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_cyc(20); m_low = 1'b1;
    wait_cyc(20); scl = 1'b1;
    wait_cyc(20); m_low = 1'b0;
    wait_cyc(40);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(!b[i], s);
    clk_bit(1'b0, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      b[i] = s;
    end
    clk_bit(!nack, s);
    m_low = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < WCYC + 500 && busy; i++) wait_cyc(1);
    wait_cyc(5);
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int w0;
    for (int i = 0; i < 256; i++) exp_m[i] = init_val(i);
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    check(standby && !busy && !sda_low && !wr_valid && !rd_valid, "R1 reset outputs",
          {standby, busy, sda_low, wr_valid, rd_valid}, 5'b10000);

    // R3 short SDA low pulse while SCL high is not a start
    m_low = 1'b1; wait_cyc(2); m_low = 1'b0;
    wait_cyc(30);
    check(standby == 1'b1, "R3 glitch ignored, standby", standby, 1);

    // R2 bits clocked with no start get no acknowledge
    scl = 1'b0;
    w0 = n_wr;
    send_byte(DEV_W, ack);
    check(!ack, "R2 no ack before start", ack, 0);
    send_byte(8'h20, ack);
    send_byte(8'h77, ack);
    check(n_wr == w0 && standby, "R2 no write before start", n_wr, w0);
    wait_cyc(20); scl = 1'b1; wait_cyc(40);

    // vector table: single-byte write, busy wait, random read back
    for (int v = 0; v < 4; v++) begin
      logic [7:0] wa, wd;
      wa = VEC[v][15:8]; wd = VEC[v][7:0];
      bus_start();
      wait_cyc(15);
      check(standby == 1'b0, "R2 start leaves standby", standby, 0);
      send_byte(DEV_W, ack); check(ack, "R4 device byte ack", ack, 1);
      send_byte(wa, ack);    check(ack, "R5 word address ack", ack, 1);
      send_byte(wd, ack);    check(ack, "R5 data ack", ack, 1);
      exp_m[wa] = wd;
      check(last_wa == wa && last_wd == wd, "R5 write request",
            {last_wa, last_wd}, {wa, wd});
      bus_stop();
      wait_cyc(20);
      check(busy && !standby, "R6 R7 busy after write stop", {busy, standby}, 2'b10);
      if (v == 0) begin
        bus_start();
        send_byte(DEV_W, ack);
        check(!ack, "R6 no ack while busy", ack, 0);
        bus_stop();
      end
      wait_idle();
      check(!busy && standby, "R7 standby after busy", {busy, standby}, 2'b01);
      bus_start();
      send_byte(DEV_W, ack);
      send_byte(wa, ack);
      bus_start();
      send_byte(DEV_R, ack); check(ack, "R8 read device ack", ack, 1);
      recv_byte(1'b1, b);
      check(b == exp_m[wa], "R8 random read data", b, exp_m[wa]);
      bus_stop();
    end

    // R11 current-address sequential read, R9 ack/nack handling
    bus_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, b);
    check(b == exp_m[8'h14], "R11 current address read", b, exp_m[8'h14]);
    recv_byte(1'b1, b);
    check(b == exp_m[8'h15], "R9 ack continues to next byte", b, exp_m[8'h15]);
    recv_byte(1'b1, b);
    check(b == 8'hFF, "R9 released after master nack", b, 8'hFF);
    bus_stop();
    wait_cyc(20);
    check(standby == 1'b1, "R7 standby after read stop", standby, 1);

    // R4 wrong device address: no ack, rest ignored
    w0 = n_wr;
    bus_start();
    send_byte(DEV_BAD, ack);
    check(!ack, "R4 wrong address no ack", ack, 0);
    send_byte(8'h00, ack);
    check(!ack && n_wr == w0, "R4 bytes ignored after mismatch", n_wr, w0);
    bus_stop();
    wait_cyc(20);
    check(!busy, "R6 no busy without write", busy, 0);

    // R10 start inside a byte restarts reception
    begin
      bit s;
      bus_start();
      clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b0, s);
      bus_start();
      send_byte(DEV_W, ack); check(ack, "R10 device ack after restart", ack, 1);
      send_byte(8'h40, ack);
      send_byte(8'h5A, ack);
      exp_m[8'h40] = 8'h5A;
      check(last_wa == 8'h40 && last_wd == 8'h5A, "R10 write after restart",
            {last_wa, last_wd}, 16'h405A);
      bus_stop();
      wait_idle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_cyc(190000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule